// File: doc/BRIEF.md
# Comparator Window-Check Sequencer

This block decides whether an analog input sits inside a voltage window using only two comparator readings, with no successive-approximation search. It drives the digital side of a 10-bit DAC and comparator front end: the DAC code, the sample/hold control, the precharge control, a one-hot input mux enable and the converter enable. A window is given as two DAC codes. Each code is computed as 1024 × nominal voltage × tolerance factor ÷ reference. For example, 1.5 V ±5% against a 5 V reference gives a low code of 0x123 and a high code of 0x143.

After a start request the block powers the converter and waits a settling interval. It then runs two checks. The first uses the low code and requires the comparator to read 0. The second uses the high code and requires the comparator to read 1. Each check samples the input with the DAC parked at mid-scale (0x200), then holds it, applies the limit code with precharge released, reads the comparator and returns the DAC to mid-scale. A one-cycle done pulse ends the run, with pass or fail valid in that cycle. If the hold phase of a check would run past a set number of cycles, the run aborts and raises an error.

Top module: `win_check_seq`

## Requirements
- R1: While reset is asserted and afterwards in idle: dac_code is 0x200, hold is 1, prech is 1, mux_en is all zero, conv_en is 0, and done, pass, fail and err are 0.
- R2: When start is seen in idle, conv_en is 1 from the next cycle until the end of the run. During the run mux_en has exactly bit number chan set. done rises SETTLE_CYC + 2·(4·STEP_CYC + 1) cycles after the clock edge that accepted start.
- R3: Whenever hold is 0 (sample mode), dac_code equals the mid-scale code 0x200.
- R4: The low check passes only if cmp_in reads 0 while dac_code carries lim_lo with hold at 1.
- R5: The high check passes only if cmp_in reads 1 while dac_code carries lim_hi with hold at 1.
- R6: done is high for exactly one cycle. In that cycle pass is 1 exactly when both checks passed, and fail is its complement. pass and fail keep their values until the next accepted start.
- R7: hold first goes low exactly SETTLE_CYC cycles after the accepting edge, so nothing is sampled before the settling interval ends.
- R8: mux_en never has more than one bit set.
- R9: hold stays high for at most HOLD_MAX consecutive cycles within a check. If that limit would be passed, the run ends early: done pulses with err=1, fail=1 and pass=0, HOLD_MAX + STEP_CYC + SETTLE_CYC cycles after the accepting edge.
- R10: start has no effect while a run is in progress. lim_lo, lim_hi and chan are captured at the accepting edge, so later changes to them do not alter the running test.
- R11: prech is 0 only while hold is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a window test (accepted in idle only) |
| lim_lo | input | DAC_W | Low limit code |
| lim_hi | input | DAC_W | High limit code |
| chan | input | $clog2(NCH) | Input channel to route through the mux |
| cmp_in | input | 1 | Comparator output: 1 when the DAC level exceeds the held input |
| dac_code | output | DAC_W | Code driven to the DAC |
| hold | output | 1 | 0 = sample, 1 = hold |
| prech | output | 1 | Precharge control, 1 = precharging |
| mux_en | output | NCH | One-hot input mux enable |
| conv_en | output | 1 | Converter enable |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Window test passed |
| fail | output | 1 | Window test failed or aborted |
| err | output | 1 | Hold-time abort occurred |

## Verification
All results follow from the accepting edge with a fixed latency. The first sample cycle is due after SETTLE_CYC cycles. done is due after SETTLE_CYC + 2·(4·STEP_CYC+1) cycles, or after SETTLE_CYC + STEP_CYC + HOLD_MAX cycles on a hold-time abort. For each start, the driver records the accepting cycle and queues the expected verdict with its due cycle. A monitor samples on the falling edge, pops the entry when done appears, and compares both the verdict and the cycle number. A second check, made two cycles later, confirms that pass and fail are held.

// File: rtl/wc_pkg.sv
package wc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SAMPLE,
        ST_HOLDMID,
        ST_APPLY,
        ST_READ,
        ST_RESTORE,
        ST_FIN
    } wc_state_e;

    typedef struct packed {
        logic conv_en;
        logic hold;
        logic prech;
        logic use_limit;
    } fe_ctrl_t;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic hold_phase(wc_state_e s);
        return (s == ST_HOLDMID) || (s == ST_APPLY) ||
               (s == ST_READ)    || (s == ST_RESTORE);
    endfunction

    function automatic fe_ctrl_t fe_decode(wc_state_e s);
        fe_ctrl_t c;
        c = '{conv_en: 1'b0, hold: 1'b1, prech: 1'b1, use_limit: 1'b0};
        case (s)
            ST_SETTLE:  c.conv_en = 1'b1;
            ST_SAMPLE:  begin c.conv_en = 1'b1; c.hold = 1'b0; end
            ST_HOLDMID: c.conv_en = 1'b1;
            ST_APPLY,
            ST_READ:    begin c.conv_en = 1'b1; c.prech = 1'b0; c.use_limit = 1'b1; end
            ST_RESTORE: c.conv_en = 1'b1;
            default:    ;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/wc_step_timer.sv
module wc_step_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wc_mux_dec.sv
module wc_mux_dec #(
    parameter int NCH = 8,
    parameter int SW  = 3
) (
    input  logic           en,
    input  logic [SW-1:0]  sel,
    output logic [NCH-1:0] onehot
);
    for (genvar i = 0; i < NCH; i++) begin : g_line
        assign onehot[i] = en && (sel == SW'(i));
    end
endmodule

// File: rtl/wc_limit_regs.sv
module wc_limit_regs #(
    parameter int DAC_W = 10,
    parameter int SW    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap,
    input  logic [DAC_W-1:0] lo_in,
    input  logic [DAC_W-1:0] hi_in,
    input  logic [SW-1:0]    ch_in,
    input  logic             use_limit,
    input  logic             upper,
    output logic [DAC_W-1:0] code,
    output logic [SW-1:0]    ch
);
    localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

    logic [DAC_W-1:0] lo_q, hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
            ch   <= '0;
        end else if (cap) begin
            lo_q <= lo_in;
            hi_q <= hi_in;
            ch   <= ch_in;
        end
    end

    always_comb begin
        if (!use_limit)
            code = MID;
        else if (upper)
            code = hi_q;
        else
            code = lo_q;
    end
endmodule

// File: rtl/wc_fsm.sv
module wc_fsm
    import wc_pkg::*;
#(
    parameter int SETTLE_CYC = 25,
    parameter int STEP_CYC   = 2,
    parameter int HOLD_MAX   = 16,
    parameter int CW         = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          cmp,
    input  logic          tmr_zero,
    output wc_state_e     state,
    output logic          upper,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output logic          cap,
    output logic          done,
    output logic          pass,
    output logic          fail,
    output logic          err
);
    localparam int HW = $clog2(HOLD_MAX + 1);

    wc_state_e     nxt;
    logic [HW-1:0] hcnt;
    logic          ok_lo, ok_hi, abort, read_ok;

    function automatic logic [CW-1:0] len_of(wc_state_e s);
        case (s)
            ST_SETTLE:  return CW'(SETTLE_CYC - 1);
            ST_SAMPLE,
            ST_HOLDMID,
            ST_APPLY,
            ST_RESTORE: return CW'(STEP_CYC - 1);
            default:    return '0;
        endcase
    endfunction

    // R9: stop before hold would exceed HOLD_MAX cycles in one check
    assign abort   = hold_phase(state) && (hcnt == HW'(HOLD_MAX - 1)) &&
                     !(state == ST_RESTORE && tmr_zero);
    // R4/R5: low limit needs comparator 0, high limit needs 1
    assign read_ok = upper ? cmp : !cmp;
    assign cap     = (state == ST_IDLE) && start;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE:    if (start) nxt = ST_SETTLE;
            ST_SETTLE:  if (tmr_zero) nxt = ST_SAMPLE;
            ST_SAMPLE:  if (tmr_zero) nxt = ST_HOLDMID;
            ST_HOLDMID: if (tmr_zero) nxt = ST_APPLY;
            ST_APPLY:   if (tmr_zero) nxt = ST_READ;
            ST_READ:    nxt = ST_RESTORE;
            ST_RESTORE: if (tmr_zero) nxt = upper ? ST_FIN : ST_SAMPLE;
            ST_FIN:     nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
        if (abort)
            nxt = ST_FIN;
    end

    assign tmr_load = (nxt != state);
    assign tmr_val  = len_of(nxt);
    assign done     = (state == ST_FIN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            upper <= 1'b0;
            hcnt  <= '0;
            ok_lo <= 1'b0;
            ok_hi <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
            err   <= 1'b0;
        end else begin
            state <= nxt;
            hcnt  <= hold_phase(state) ? hcnt + 1'b1 : '0;
            if (cap) begin
                upper <= 1'b0;
                ok_lo <= 1'b0;
                ok_hi <= 1'b0;
                pass  <= 1'b0;
                fail  <= 1'b0;
                err   <= 1'b0;
            end
            if (state == ST_READ) begin
                if (upper) ok_hi <= read_ok;
                else       ok_lo <= read_ok;
            end
            if (state == ST_RESTORE && tmr_zero && !upper)
                upper <= 1'b1;
            if (abort) begin
                err  <= 1'b1;
                fail <= 1'b1;
                pass <= 1'b0;
            end else if (state == ST_RESTORE && tmr_zero && upper) begin
                pass <= ok_lo & ok_hi;
                fail <= !(ok_lo & ok_hi);
            end
        end
    end
endmodule

// File: rtl/win_check_seq.sv
module win_check_seq
    import wc_pkg::*;
#(
    parameter int DAC_W      = 10,
    parameter int NCH        = 8,
    parameter int SETTLE_CYC = 25,
    parameter int STEP_CYC   = 2,
    parameter int HOLD_MAX   = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic [DAC_W-1:0]       lim_lo,
    input  logic [DAC_W-1:0]       lim_hi,
    input  logic [$clog2(NCH)-1:0] chan,
    input  logic                   cmp_in,
    output logic [DAC_W-1:0]       dac_code,
    output logic                   hold,
    output logic                   prech,
    output logic [NCH-1:0]         mux_en,
    output logic                   conv_en,
    output logic                   done,
    output logic                   pass,
    output logic                   fail,
    output logic                   err
);
    localparam int SW   = $clog2(NCH);
    localparam int TMAX = max3(SETTLE_CYC, STEP_CYC, HOLD_MAX);
    localparam int CW   = $clog2(TMAX + 1);

    wc_state_e     state;
    fe_ctrl_t      fe;
    logic          upper, tmr_load, tmr_zero, cap;
    logic [CW-1:0] tmr_val;
    logic [SW-1:0] ch_q;

    wc_fsm #(
        .SETTLE_CYC(SETTLE_CYC),
        .STEP_CYC  (STEP_CYC),
        .HOLD_MAX  (HOLD_MAX),
        .CW        (CW)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cmp     (cmp_in),
        .tmr_zero(tmr_zero),
        .state   (state),
        .upper   (upper),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .cap     (cap),
        .done    (done),
        .pass    (pass),
        .fail    (fail),
        .err     (err)
    );

    wc_step_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .zero    (tmr_zero)
    );

    assign fe      = fe_decode(state);
    assign conv_en = fe.conv_en;
    assign hold    = fe.hold;
    assign prech   = fe.prech;

    wc_limit_regs #(.DAC_W(DAC_W), .SW(SW)) u_lim (
        .clk      (clk),
        .rst      (rst),
        .cap      (cap),
        .lo_in    (lim_lo),
        .hi_in    (lim_hi),
        .ch_in    (chan),
        .use_limit(fe.use_limit),
        .upper    (upper),
        .code     (dac_code),
        .ch       (ch_q)
    );

    wc_mux_dec #(.NCH(NCH), .SW(SW)) u_mux (
        .en    (fe.conv_en),
        .sel   (ch_q),
        .onehot(mux_en)
    );
endmodule

// File: rtl/win_check_seq_chk.sv
module win_check_seq_chk #(
    parameter int DAC_W      = 10,
    parameter int NCH        = 8,
    parameter int SETTLE_CYC = 25,
    parameter int HOLD_MAX   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             pass,
    input logic             fail,
    input logic             err,
    input logic [DAC_W-1:0] dac_code,
    input logic             hold,
    input logic             prech,
    input logic [NCH-1:0]   mux_en,
    input logic             conv_en
);
    localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W - 1);

    int unsigned en_cnt;
    int unsigned hold_cnt;
    logic        sampled;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_cnt   <= 0;
            hold_cnt <= 0;
            sampled  <= 1'b0;
        end else begin
            en_cnt   <= conv_en ? ((en_cnt < SETTLE_CYC) ? en_cnt + 1 : en_cnt) : 0;
            sampled  <= conv_en && (sampled || !hold);
            hold_cnt <= (conv_en && hold && sampled) ? hold_cnt + 1 : 0;
        end
    end

    p_mid_in_sample_r3: assert property (@(posedge clk) disable iff (rst)
        !hold |-> dac_code == MID);

    p_settle_first_r7: assert property (@(posedge clk) disable iff (rst)
        !hold |-> en_cnt >= SETTLE_CYC);

    p_mux_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(mux_en));

    p_mux_with_conv_r2: assert property (@(posedge clk) disable iff (rst)
        conv_en |-> $countones(mux_en) == 1);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_verdict_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(pass && fail));

    p_hold_limit_r9: assert property (@(posedge clk) disable iff (rst)
        hold_cnt <= HOLD_MAX);

    p_err_fails_r9: assert property (@(posedge clk) disable iff (rst)
        err |-> fail && !pass);

    p_prech_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !prech |-> hold);
endmodule

bind win_check_seq win_check_seq_chk #(
    .DAC_W     (DAC_W),
    .NCH       (NCH),
    .SETTLE_CYC(SETTLE_CYC),
    .HOLD_MAX  (HOLD_MAX)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .done    (done),
    .pass    (pass),
    .fail    (fail),
    .err     (err),
    .dac_code(dac_code),
    .hold    (hold),
    .prech   (prech),
    .mux_en  (mux_en),
    .conv_en (conv_en)
);

// File: tb/win_check_seq_tb.sv
module win_check_seq_tb;
    localparam int DW  = 10;
    localparam int NCH = 8;
    localparam int SW  = 3;
    localparam int ST  = 25, SP = 2, HM = 16;
    localparam int LAT = ST + 2 * (4 * SP + 1);
    localparam int ST_E = 3, SP_E = 4, HM_E = 6;
    localparam int LAT_E = ST_E + SP_E + HM_E;
    localparam logic [DW-1:0] MID = 10'h200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic          start = 1'b0, start_e = 1'b0;
    logic [DW-1:0] lo = '0, hi = '0, vin = '0, vin_e = '0;
    logic [SW-1:0] ch = '0;
    logic          cmp, cmp_e;
    logic [DW-1:0] dac, dac_e;
    logic          hold, prech, conv, done, pass, fail, err;
    logic          hold_e, prech_e, conv_e, done_e, pass_e, fail_e, err_e;
    logic [NCH-1:0] mux, mux_e;

    assign cmp   = dac > vin;
    assign cmp_e = dac_e > vin_e;

    win_check_seq #(.DAC_W(DW), .NCH(NCH), .SETTLE_CYC(ST), .STEP_CYC(SP), .HOLD_MAX(HM)) u_dut (
        .clk(clk), .rst(rst), .start(start), .lim_lo(lo), .lim_hi(hi), .chan(ch),
        .cmp_in(cmp), .dac_code(dac), .hold(hold), .prech(prech), .mux_en(mux),
        .conv_en(conv), .done(done), .pass(pass), .fail(fail), .err(err));

    win_check_seq #(.DAC_W(DW), .NCH(NCH), .SETTLE_CYC(ST_E), .STEP_CYC(SP_E), .HOLD_MAX(HM_E)) u_dut_err (
        .clk(clk), .rst(rst), .start(start_e), .lim_lo(lo), .lim_hi(hi), .chan(ch),
        .cmp_in(cmp_e), .dac_code(dac_e), .hold(hold_e), .prech(prech_e), .mux_en(mux_e),
        .conv_en(conv_e), .done(done_e), .pass(pass_e), .fail(fail_e), .err(err_e));

    typedef struct {
        logic p;
        logic f;
        int   due;
    } exp_t;

    exp_t q[$];
    exp_t mon_e;
    int   checks = 0, failures = 0;
    int   v3 = 0, v11 = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (q.size() == 0) begin
                chk(1'b0, "R10 unexpected done", 1, 0);
            end else begin
                mon_e = q.pop_front();
                chk(pass == mon_e.p, "R6 pass verdict (R4/R5)", int'(pass), int'(mon_e.p));
                chk(fail == mon_e.f, "R6 fail verdict", int'(fail), int'(mon_e.f));
                chk(err == 1'b0, "R9 no error in normal run", int'(err), 0);
                chk(cyc == mon_e.due, "R2 done latency", cyc, mon_e.due);
            end
        end
        if (!rst && !hold && dac != MID) v3++;
        if (!rst && !prech && !hold) v11++;
    end

    task automatic run(input logic [SW-1:0] c, input logic [DW-1:0] l, input logic [DW-1:0] h,
                       input logic [DW-1:0] v, input bit disturb);
        exp_t e;
        int   sc;
        int   guard;
        @(negedge clk);
        vin = v; lo = l; hi = h; ch = c; start = 1'b1;
        sc = cyc + 1;
        e.p = (l <= v) && (h > v);
        e.f = !e.p;
        e.due = sc + LAT;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
        chk(conv == 1'b1, "R2 converter enabled", int'(conv), 1);
        chk(mux == NCH'(1) << c, "R2 mux follows channel", int'(mux), int'(NCH'(1) << c));
        if (disturb) begin
            repeat (5) @(negedge clk);
            start = 1'b1; lo = 10'h000; hi = 10'h3FF; ch = c + 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk(mux == NCH'(1) << c, "R10 channel kept while busy", int'(mux), int'(NCH'(1) << c));
        end
        guard = 0;
        while (hold && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(cyc - sc == ST, "R7 first sample after settle", cyc - sc, ST);
        guard = 0;
        while (q.size() != 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R6 done single cycle", int'(done), 0);
        chk(pass == e.p, "R6 pass held", int'(pass), int'(e.p));
        chk(conv == 1'b0 && mux == '0, "R1 idle after run", int'(mux), 0);
    endtask

    initial begin : wdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        int sc;
        int guard;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk(dac == MID, "R1 dac mid in reset", int'(dac), int'(MID));
        chk(hold && prech, "R1 hold/prech high in reset", int'({hold, prech}), 3);
        chk(mux == '0 && !conv, "R1 mux/conv cleared in reset", int'(mux), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !pass && !fail && !err, "R1 flags clear", int'({done, pass, fail, err}), 0);
        chk(dac == MID && hold && prech && !conv, "R1 idle front end", int'(dac), int'(MID));

        // R4/R5 window cases: comparator is 1 when dac > vin
        run(3'd3, 10'h123, 10'h143, 10'd300, 1'b0);  // inside: pass
        run(3'd0, 10'h123, 10'h143, 10'd280, 1'b0);  // below: R4 fails
        run(3'd7, 10'h123, 10'h143, 10'd330, 1'b0);  // above: R5 fails
        run(3'd2, 10'h123, 10'h143, 10'h123, 1'b0);  // equal to low: pass
        run(3'd1, 10'h123, 10'h143, 10'h143, 1'b0);  // equal to high: fail
        run(3'd5, 10'h100, 10'h300, 10'd600, 1'b1);  // R10 restart attempt while busy
        run(3'd4, 10'h100, 10'h300, 10'd200, 1'b0);

        chk(v3 == 0, "R3 mid code during sample", v3, 0);
        chk(v11 == 0, "R11 precharge off only in hold", v11, 0);

        // R9: hold-time abort on the second instance
        @(negedge clk);
        vin_e = 10'd300; lo = 10'h123; hi = 10'h143; ch = 3'd6; start_e = 1'b1;
        sc = cyc + 1;
        @(negedge clk);
        start_e = 1'b0;
        guard = 0;
        while (!done_e && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(cyc - sc == LAT_E, "R9 abort latency", cyc - sc, LAT_E);
        chk(err_e && fail_e && !pass_e, "R9 abort verdict", int'({err_e, fail_e, pass_e}), 6);
        @(negedge clk);
        chk(!done_e && !conv_e, "R9 back to idle", int'({done_e, conv_e}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule